// File: doc/BRIEF.md
# Sliding-Window Switch Sample Counter

This block watches a single home or limit-switch line and turns it into a number that tells how strongly the switch has been asserted lately. The raw line is first brought into the clock domain through a two-stage synchroniser. On every control tick the synchronised level, optionally inverted by a polarity bit, is appended to a short history of the most recent samples. The block reports how many of the last ten samples were asserted, a value from 0 to 10.

A consumer compares this count against its own thresholds. Typical use is asymmetric: declare the switch firmly engaged at a high count (for example 6 when first deciding, 8 while searching), and firmly released at a count of 1 or less. Those decisions stay outside this block. A synchronous clear empties the history so a new search starts from a known state.

Top module: `mark_window_counter`

## Requirements
- R1: After reset the reported count is 0 and the history holds no asserted samples, so the first tick with an asserted mark yields a count of 1.
- R2: The sample taken on a tick is the synchronised switch level XOR the polarity bit `invert_pol` (1 means an active-low switch).
- R3: On each tick the history moves one place towards older samples and the new sample takes the newest place; only the ten newest samples count, so a sample drops out ten ticks after it entered.
- R4: The count equals the number of asserted samples among the ten newest and never exceeds 10, even after more than ten asserted ticks in a row.
- R5: The count is registered: at the clock edge that samples a tick it still shows the old value, and the new value appears at the next clock edge.
- R6: Without a tick the history and the count hold, whatever the switch line does.
- R7: A clear empties the history and the count reads 0 after the edge that samples the clear; a clear has priority over a tick in the same cycle.
- R8: The switch line passes two flip-flops before sampling: a level applied less than two clock edges before the tick edge is not yet seen, the previous level is sampled instead.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle sampling strobe |
| sw_raw | input | 1 | Raw asynchronous switch line |
| invert_pol | input | 1 | Polarity select, 1 inverts the sample |
| clear | input | 1 | Synchronous history clear |
| mark_count | output | 4 | Asserted samples among the last ten |

## Verification
The bench drives a long pseudo-random sample stream with the polarity bit flipping in blocks and compares every count against a bench-side window model; an off-by-one window length or a wrong shift direction shows up as counts that disagree once samples age out. Runs of more than ten asserted and then deasserted ticks probe saturation at 10 and the fall to 0, which a design that counted the whole register would overshoot. It also checks the count one edge after a tick to catch an unregistered output, drives the line without ticks to catch a history that moves on its own, collides clear with tick to catch wrong priority, and changes the line right before a tick to catch a missing or extra synchroniser stage.

// File: rtl/mwc_pkg.sv
package mwc_pkg;
  localparam int unsigned WIN_LEN = 10;
  localparam int unsigned CNT_W   = $clog2(WIN_LEN + 1);
  typedef logic [WIN_LEN-1:0] win_t;
  typedef logic [CNT_W-1:0]   cnt_t;
endpackage

// File: rtl/mwc_sync.sv
module mwc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d[0] = d_async;
    for (int i = 1; i < STAGES; i++) chain_d[i] = chain_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/mwc_history.sv
module mwc_history #(
  parameter int unsigned WIN = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           shift_en,
  input  logic           clear,
  input  logic           sample,
  output logic [WIN-1:0] hist
);
  logic [WIN-1:0] hist_q;
  logic [WIN-1:0] hist_d;
  logic           hist_en;

  always_comb begin
    hist_en = shift_en | clear;
    if (clear) hist_d = '0;
    else       hist_d = {hist_q[WIN-2:0], sample};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hist_q <= '0;
    else if (hist_en) hist_q <= hist_d;
  end

  assign hist = hist_q;
endmodule

// File: rtl/mwc_popcount.sv
module mwc_popcount #(
  parameter int unsigned WIN = 10,
  localparam int unsigned CW = $clog2(WIN + 1)
) (
  input  logic [WIN-1:0] bits,
  output logic [CW-1:0]  ones
);
  always_comb begin
    ones = '0;
    for (int i = 0; i < WIN; i++) ones = ones + CW'(bits[i]);
  end
endmodule

// File: rtl/mark_window_counter.sv
module mark_window_counter
  import mwc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             sw_raw,
  input  logic             invert_pol,
  input  logic             clear,
  output logic [CNT_W-1:0] mark_count
);
  logic sw_sync;
  logic mark_bit;
  win_t hist;
  cnt_t ones;
  logic tick_d_q;
  cnt_t count_q;
  cnt_t count_d;
  logic count_en;

  mwc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(sw_raw), .q_sync(sw_sync)
  );

  assign mark_bit = sw_sync ^ invert_pol;

  mwc_history #(.WIN(WIN_LEN)) u_hist (
    .clk(clk), .rst_n(rst_n), .shift_en(tick), .clear(clear),
    .sample(mark_bit), .hist(hist)
  );

  mwc_popcount #(.WIN(WIN_LEN)) u_pop (
    .bits(hist), .ones(ones)
  );

  always_comb begin
    count_en = tick_d_q | clear;
    count_d  = clear ? '0 : ones;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_d_q <= 1'b0;
    else        tick_d_q <= tick & ~clear;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (count_en) count_q <= count_d;
  end

  assign mark_count = count_q;
endmodule

// File: rtl/mark_window_counter_chk.sv
module mark_window_counter_chk
  import mwc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             clear,
  input logic [CNT_W-1:0] mark_count
);
  p_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(mark_count) <= int'(WIN_LEN));

  p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (mark_count == '0));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(tick) && !clear) |=> $stable(mark_count));

  p_unit_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> ((int'(mark_count) <= int'($past(mark_count)) + 1) &&
                (int'(mark_count) + 1 >= int'($past(mark_count)))));
endmodule

bind mark_window_counter mark_window_counter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .clear(clear), .mark_count(mark_count)
);

// File: tb/test_mark_window_counter.sv
module test_mark_window_counter;
  localparam int CLK_PERIOD = 10;
  localparam int WIN = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick;
  logic       sw_raw;
  logic       invert_pol;
  logic       clear;
  logic [3:0] mark_count;

  int vectors = 0;
  int errors  = 0;
  logic [WIN-1:0] model = '0;
  logic [31:0] rng = 32'h1234_5679;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mark_window_counter i_mark_window_counter (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sw_raw(sw_raw),
    .invert_pol(invert_pol), .clear(clear), .mark_count(mark_count)
  );

  function automatic int model_ones();
    int s = 0;
    for (int i = 0; i < WIN; i++) s += int'(model[i]);
    return s;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: count %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_tick(input bit r, input string req);
    int old;
    sw_raw = r;
    repeat (3) @(negedge clk);
    old = int'(mark_count);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    check("R5 old value at tick edge", int'(mark_count), old);
    model = {model[WIN-2:0], r ^ invert_pol};
    @(negedge clk);
    check(req, int'(mark_count), model_ones());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    int old;
    rst_n = 1'b0; tick = 1'b0; sw_raw = 1'b0; invert_pol = 1'b0; clear = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset count", int'(mark_count), 0);
    do_tick(1'b1, "R1 first asserted tick");

    // R2 R3 R4: pseudo-random stream, polarity flipped every 50 ticks
    for (int n = 0; n < 400; n++) begin
      if (n % 50 == 0) invert_pol = ~invert_pol;
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
      do_tick(rng[0], "R2 R3 window count");
    end

    // R4 saturation at 10 and fall to 0
    invert_pol = 1'b1;
    for (int n = 0; n < 13; n++) do_tick(1'b0, "R4 run of asserted samples");
    check("R4 saturates at 10", int'(mark_count), 10);
    for (int n = 0; n < 10; n++) do_tick(1'b1, "R3 samples age out");
    check("R3 empty window", int'(mark_count), 0);
    invert_pol = 1'b0;
    for (int n = 0; n < 6; n++) do_tick(n[0], "R3 alternating");

    // R6 no tick: line toggles, count holds
    old = int'(mark_count);
    for (int n = 0; n < 12; n++) begin
      sw_raw = ~sw_raw;
      @(negedge clk);
      check("R6 hold without tick", int'(mark_count), old);
    end
    do_tick(1'b1, "R6 history untouched by line activity");

    // R7 clear alone
    for (int n = 0; n < 4; n++) do_tick(1'b1, "R7 fill");
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    model = '0;
    check("R7 clear zeroes count", int'(mark_count), 0);
    do_tick(1'b1, "R7 history empty after clear");

    // R7 clear colliding with tick
    for (int n = 0; n < 5; n++) do_tick(1'b1, "R7 fill");
    clear = 1'b1; tick = 1'b1;
    @(negedge clk);
    clear = 1'b0; tick = 1'b0;
    model = '0;
    @(negedge clk);
    check("R7 clear wins over tick", int'(mark_count), 0);
    do_tick(1'b1, "R7 no stale sample after collision");

    // R8 synchroniser latency
    sw_raw = 1'b0;
    repeat (3) @(negedge clk);
    sw_raw = 1'b1; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    model = {model[WIN-2:0], 1'b0};
    @(negedge clk);
    check("R8 same-cycle change not seen", int'(mark_count), model_ones());
    sw_raw = 1'b0;
    repeat (3) @(negedge clk);
    sw_raw = 1'b1;
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    model = {model[WIN-2:0], 1'b0};
    @(negedge clk);
    check("R8 one-edge-old change not seen", int'(mark_count), model_ones());
    do_tick(1'b1, "R8 settled level seen");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule